// File: doc/BRIEF.md
# USB Receive Bit Timing Recovery

This block turns a USB differential receive pair, sampled by the 48 MHz core clock, into a single-cycle bit strobe and the line state captured with it. The strobe is a synchronous clock enable: downstream logic (NRZI decoder, bit unstuffer, framer) stays on the core clock and acts only in cycles where the strobe is high. The block does not generate or output a derived clock.

The raw pair first goes through a two-flop synchronizer. An optional filter then passes a new line state only after two equal samples in a row. A phase counter is cleared on every line change and fires one bit period later in the middle of each bit. That period is 4 core cycles at full speed and 32 at low speed, selected by a speed input. Clearing the counter on every change lets it follow a transmitter running a few percent fast or slow. The counter only fires while it is locked. It locks on a change between the two differential states. It drops lock on a single-ended line state, or when a run of bits with no line change grows longer than the bit stuffing rule allows.

Top module: `usb_bit_recovery`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, `bit_stb_o`, `line_p_o` and `line_m_o` are all 0.
- R2: The input latency is L = 2 cycles without the filter (`DEGLITCH`=0) and L = 4 with it (default). When a locking change reaches the pins before clock edge 0, the first strobe is visible after edge L + P/2, where P is the bit period in cycles.
- R3: While the line holds a differential state, strobes repeat every P cycles: P = 4 when `low_speed_i`=0 and P = 32 when `low_speed_i`=1.
- R4: With each strobe, `line_p_o`/`line_m_o` carry the filtered pair seen in the cycle the strobe was decided. They stay unchanged in every cycle without a strobe.
- R5: When every bit lasts 3.8 or 4.2 cycles (5% off the full-speed period) and no run without a line change exceeds 4 bits, exactly one strobe falls inside each bit and carries that bit's state.
- R6: Two strobes are never closer than P/2+1 cycles at full speed, so no bit gets a second strobe.
- R7: No strobe is issued while the pair is single-ended (`p == m`). A change from single-ended to a differential state does not lock the tracker, so no strobes follow end-of-packet.
- R8: After reset, or after lock is lost, a line that holds one differential state produces no strobes. The first change between the two differential states (p=1,m=0 to p=0,m=1 or back) locks the tracker.
- R9: After `RUN_LIMIT` (default 7) strobes with no line change, the tracker unlocks. No further strobe is issued until the next change between differential states.
- R10: With the filter present, a change that lasts one sample at the pins causes no lock and no strobe. A change that lasts two samples is passed on and locks the tracker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| low_speed_i | input | 1 | 1 selects the 1.5 Mb/s period, 0 the 12 Mb/s period |
| line_p_i | input | 1 | Raw D+ receive level, asynchronous |
| line_m_i | input | 1 | Raw D- receive level, asynchronous |
| bit_stb_o | output | 1 | One-cycle bit-sample enable |
| line_p_o | output | 1 | D+ level captured with the strobe |
| line_m_o | output | 1 | D- level captured with the strobe |

## Verification
The hardest case to reach from the pins is a clock mismatch that pushes a strobe against the next line change. In that case a strobe could be lost, or fire twice within one bit. The bench drives packets whose bit boundaries come from a fractional accumulator at 3.8 and 4.2 cycles per bit. This places each boundary in every quantized position relative to the strobe phase. The bench then checks one strobe per bit, the sampled value and the minimum spacing. Exact-rate packets check the strobe cycle against an arithmetic formula for both latency variants. Held runs and one- and two-cycle pulses on an idle line check the unlock limit and the filter.

// File: rtl/usb_brr_pkg.sv
// Package: shared line-pair type and helpers for the bit timing recovery block.
// Assumes: the pair is sampled as two independent single-bit levels.
package usb_brr_pkg;

    typedef struct packed {
        logic dp;
        logic dm;
    } pair_t;

    localparam pair_t PAIR_SE0 = '{dp: 1'b0, dm: 1'b0};

    // True when both wires carry the same level (not a differential state).
    function automatic logic pair_single_ended(pair_t x);
        return x.dp == x.dm;
    endfunction

endpackage

// File: rtl/usb_brr_sync.sv
// Module: two-stage synchronizer for the raw receive pair.
// Does: retimes the asynchronous pair into the core clock domain, 2 cycles latency.
// Assumes: the pair wires may skew by a cycle; later stages tolerate that.
module usb_brr_sync
    import usb_brr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pair_t raw_i,
    output pair_t sync_o
);

    pair_t stage1_q;
    pair_t stage2_q;

    // Shift the raw pair through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= PAIR_SE0;
            stage2_q <= PAIR_SE0;
        end else begin
            stage1_q <= raw_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/usb_brr_deglitch.sv
// Module: glitch filter on the synchronized pair.
// Does: moves its output to a new pair value only after two equal samples in a row;
//       adds 2 cycles latency and drops any one-sample pulse.
// Assumes: input already in the core clock domain.
module usb_brr_deglitch
    import usb_brr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pair_t pair_i,
    output pair_t pair_o
);

    pair_t hist_q;
    pair_t held_q;

    // Keep the previous sample for the stability comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= PAIR_SE0;
        end else begin
            hist_q <= pair_i;
        end
    end

    // Accept the sample once it has matched its predecessor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= PAIR_SE0;
        end else if (pair_i == hist_q) begin
            held_q <= pair_i;
        end
    end

    assign pair_o = held_q;

endmodule

// File: rtl/usb_brr_tracker.sv
// Module: phase tracker and bit strobe generator.
// Does: clears a phase counter on every line change, fires a strobe at half a
//       period after it and every full period after that, while locked; locks on
//       a change between differential states, unlocks on a single-ended state or
//       after RUN_LIMIT strobes without a change.
// Assumes: FS_DIV <= LS_DIV, both even; input is the synchronized (filtered) pair.
module usb_brr_tracker
    import usb_brr_pkg::*;
#(
    parameter int FS_DIV    = 4,
    parameter int LS_DIV    = 32,
    parameter int RUN_LIMIT = 7
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  low_speed_i,
    input  pair_t pair_i,
    output logic  strobe_o,
    output pair_t sample_o
);

    localparam int PH_W  = (LS_DIV > 2) ? $clog2(LS_DIV) : 1;
    localparam int RUN_W = $clog2(RUN_LIMIT + 1);
    localparam logic [PH_W-1:0]  FS_LAST = PH_W'(FS_DIV - 1);
    localparam logic [PH_W-1:0]  LS_LAST = PH_W'(LS_DIV - 1);
    localparam logic [PH_W-1:0]  FS_MID  = PH_W'(FS_DIV / 2);
    localparam logic [PH_W-1:0]  LS_MID  = PH_W'(LS_DIV / 2);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LIMIT);

    pair_t            prev_q;
    logic [PH_W-1:0]  phase_q;
    logic [RUN_W-1:0] run_q;
    logic             locked_q;
    logic             strobe_q;
    pair_t            sample_q;

    logic [PH_W-1:0]  last_ph;
    logic [PH_W-1:0]  mid_ph;
    logic [PH_W-1:0]  phase_now;
    logic             line_edge;
    logic             cur_se;
    logic             prev_se;
    logic             at_mid;
    logic             fire;
    logic             lock_nxt;

    // Pick the period end and mid-bit phase for the selected speed.
    always_comb begin
        last_ph = low_speed_i ? LS_LAST : FS_LAST;
        mid_ph  = low_speed_i ? LS_MID  : FS_MID;
    end

    // Detect a line change and derive the phase of the current cycle.
    always_comb begin
        line_edge = (pair_i != prev_q);
        cur_se    = pair_single_ended(pair_i);
        prev_se   = pair_single_ended(prev_q);
        phase_now = line_edge ? '0 : phase_q;
        at_mid    = (phase_now == mid_ph);
        fire      = locked_q && !cur_se && !line_edge && at_mid && (run_q < RUN_MAX);
    end

    // Decide the next lock state from the line condition.
    always_comb begin
        if (cur_se) begin
            lock_nxt = 1'b0;
        end else if (line_edge) begin
            lock_nxt = !prev_se;
        end else if (at_mid && (run_q == RUN_MAX)) begin
            lock_nxt = 1'b0;
        end else begin
            lock_nxt = locked_q;
        end
    end

    // Remember the previous pair for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= PAIR_SE0;
        end else begin
            prev_q <= pair_i;
        end
    end

    // Advance the phase counter, wrapping at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_now >= last_ph) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_now + 1'b1;
        end
    end

    // Count strobes since the last line change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (line_edge) begin
            run_q <= '0;
        end else if (fire) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Hold the lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
        end else begin
            locked_q <= lock_nxt;
        end
    end

    // Register the strobe and the pair captured with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            sample_q <= PAIR_SE0;
        end else begin
            strobe_q <= fire;
            if (fire) begin
                sample_q <= pair_i;
            end
        end
    end

    assign strobe_o = strobe_q;
    assign sample_o = sample_q;

endmodule

// File: rtl/usb_bit_recovery.sv
// Module: top of the USB receive bit timing recovery.
// Does: synchronizes the raw pair, optionally filters it, and tracks bit phase
//       to produce a one-cycle sample enable plus the pair captured with it.
// Assumes: core clock of 48 MHz; the enable is a clock enable, not a clock.
module usb_bit_recovery
    import usb_brr_pkg::*;
#(
    parameter int FS_DIV    = 4,
    parameter int LS_DIV    = 32,
    parameter int RUN_LIMIT = 7,
    parameter bit DEGLITCH  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_speed_i,
    input  logic line_p_i,
    input  logic line_m_i,
    output logic bit_stb_o,
    output logic line_p_o,
    output logic line_m_o
);

    pair_t raw_pair;
    pair_t sync_pair;
    pair_t clean_pair;
    pair_t smp_pair;

    assign raw_pair = '{dp: line_p_i, dm: line_m_i};

    usb_brr_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_pair),
        .sync_o (sync_pair)
    );

    generate
        if (DEGLITCH) begin : gen_filter
            usb_brr_deglitch u_deglitch (
                .clk    (clk),
                .rst_n  (rst_n),
                .pair_i (sync_pair),
                .pair_o (clean_pair)
            );
        end else begin : gen_direct
            assign clean_pair = sync_pair;
        end
    endgenerate

    usb_brr_tracker #(
        .FS_DIV    (FS_DIV),
        .LS_DIV    (LS_DIV),
        .RUN_LIMIT (RUN_LIMIT)
    ) u_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .low_speed_i (low_speed_i),
        .pair_i      (clean_pair),
        .strobe_o    (bit_stb_o),
        .sample_o    (smp_pair)
    );

    assign line_p_o = smp_pair.dp;
    assign line_m_o = smp_pair.dm;

endmodule

// File: rtl/usb_bit_recovery_chk.sv
// Module: assertion checker for usb_bit_recovery, attached by bind.
// Does: checks reset values, strobe spacing, sample hold and single-ended suppression.
// Assumes: FS_DIV is the shorter period, so its spacing bound covers both speeds.
module usb_bit_recovery_chk #(
    parameter int FS_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic bit_stb_o,
    input logic line_p_o,
    input logic line_m_o
);

    localparam logic [7:0] GAP_SAT = 8'hFF;
    localparam logic [7:0] MIN_GAP = 8'(FS_DIV / 2);

    logic [7:0] gap_q;

    // Count cycles since the previous strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= GAP_SAT;
        end else if (bit_stb_o) begin
            gap_q <= '0;
        end else if (gap_q != GAP_SAT) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!bit_stb_o && !line_p_o && !line_m_o));

    a_r6_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb_o |-> (gap_q >= MIN_GAP));

    a_r4_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb_o |-> $stable({line_p_o, line_m_o}));

    a_r7_no_single_ended: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb_o |-> (line_p_o != line_m_o));

endmodule

bind usb_bit_recovery usb_bit_recovery_chk #(.FS_DIV(FS_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb_o (bit_stb_o),
    .line_p_o  (line_p_o),
    .line_m_o  (line_m_o)
);

// File: tb/test_usb_bit_recovery.sv
`timescale 1ns/1ps
// Bench: drives packets at exact and off-nominal bit lengths into a filtered and
// an unfiltered instance, and compares strobe timing and values with arithmetic.
module test_usb_bit_recovery;

    localparam int FS_P = 4;
    localparam int LS_P = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic low_speed = 1'b0;
    logic raw_p = 1'b1;
    logic raw_m = 1'b0;
    logic [1:0] stb;
    logic [1:0] lp;
    logic [1:0] lm;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 1'b0;

    int rn [2];
    int rcyc [2][0:255];
    logic [1:0] rval [2][0:255];

    always #2 clk = ~clk;

    usb_bit_recovery i_usb_bit_recovery (
        .clk (clk), .rst_n (rst_n), .low_speed_i (low_speed),
        .line_p_i (raw_p), .line_m_i (raw_m),
        .bit_stb_o (stb[0]), .line_p_o (lp[0]), .line_m_o (lm[0])
    );

    usb_bit_recovery #(.DEGLITCH(1'b0)) i_usb_bit_recovery_nf (
        .clk (clk), .rst_n (rst_n), .low_speed_i (low_speed),
        .line_p_i (raw_p), .line_m_i (raw_m),
        .bit_stb_o (stb[1]), .line_p_o (lp[1]), .line_m_o (lm[1])
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Record every strobe of both instances with its cycle number and value.
    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (rst_n && stb[i]) begin
                if (rn[i] < 256) begin
                    rcyc[i][rn[i]] = cyc;
                    rval[i][rn[i]] = {lp[i], lm[i]};
                end
                rn[i] = rn[i] + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic p, input logic m, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            raw_p = p;
            raw_m = m;
        end
    endtask

    // Build bit levels (1 = p high) from run lengths in nibbles, first run at level 0.
    task automatic build(input logic [31:0] runs, output logic [63:0] bits, output int nb);
        logic lvl;
        lvl = 1'b0;
        nb = 0;
        bits = '0;
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < int'(runs[4*i +: 4]); j++) begin
                bits[nb] = lvl;
                nb++;
            end
            if (runs[4*i +: 4] != 4'd0) lvl = ~lvl;
        end
    endtask

    // Send a packet: idle, bits of num/den cycles each, single-ended end, idle.
    task automatic packet(input logic [63:0] bits, input int nb, input int num, input int den,
                          input bit ls, output int c0);
        int total;
        rn[0] = 0;
        rn[1] = 0;
        low_speed = ls;
        drive(1'b1, 1'b0, 40);
        total = (nb * num + den - 1) / den;
        c0 = 0;
        for (int c = 0; c < total; c++) begin
            int k;
            @(negedge clk);
            k = (c * den) / num;
            raw_p = bits[k];
            raw_m = ~bits[k];
            if (c == 0) c0 = cyc;
        end
        drive(1'b0, 1'b0, (2 * num) / den);
        drive(1'b1, 1'b0, (3 * num) / den + 40);
    endtask

    // Compare recorded strobes with one per bit; exact mode also checks the cycle.
    task automatic verify(input int inst, input logic [63:0] bits, input int nb, input int c0,
                          input int lat, input int per, input bit exact, input string tag);
        chk(rn[inst] == nb, {tag, " strobe count (R7 none after end)"}, rn[inst], nb);
        for (int k = 0; k < nb && k < rn[inst]; k++) begin
            chk(rval[inst][k] == {bits[k], ~bits[k]}, {tag, " sampled value R4"},
                int'(rval[inst][k]), int'({bits[k], ~bits[k]}));
            if (exact)
                chk(rcyc[inst][k] == c0 + 1 + lat + per / 2 + k * per, {tag, " strobe cycle R2 R3"},
                    rcyc[inst][k], c0 + 1 + lat + per / 2 + k * per);
            if (k > 0)
                chk(rcyc[inst][k] - rcyc[inst][k-1] >= FS_P / 2 + 1, {tag, " spacing R6"},
                    rcyc[inst][k] - rcyc[inst][k-1], FS_P / 2 + 1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [63:0] bits;
        int nb;
        int c0;
        rn[0] = 0;
        rn[1] = 0;
        repeat (5) @(negedge clk);
        // R1: outputs during reset
        for (int i = 0; i < 2; i++)
            chk({stb[i], lp[i], lm[i]} == 3'b000, "R1 reset outputs", int'({stb[i], lp[i], lm[i]}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 2; i++)
            chk({stb[i], lp[i], lm[i]} == 3'b000, "R1 after reset", int'({stb[i], lp[i], lm[i]}), 0);
        // R8: idle differential line gives no strobes
        rn[0] = 0;
        rn[1] = 0;
        drive(1'b1, 1'b0, 100);
        for (int i = 0; i < 2; i++) chk(rn[i] == 0, "R8 idle no strobe", rn[i], 0);

        // R2 R3 R4: exact full-speed packet, runs up to 7
        build(32'h1323_1171, bits, nb);
        packet(bits, nb, FS_P, 1, 1'b0, c0);
        verify(0, bits, nb, c0, 4, FS_P, 1'b1, "R2 FS filtered");
        verify(1, bits, nb, c0, 2, FS_P, 1'b1, "R2 FS direct");

        // R3: exact low-speed packet
        build(32'h0021_3121, bits, nb);
        packet(bits, nb, LS_P, 1, 1'b1, c0);
        verify(0, bits, nb, c0, 4, LS_P, 1'b1, "R3 LS filtered");
        verify(1, bits, nb, c0, 2, LS_P, 1'b1, "R3 LS direct");

        // R5 R6: 5% fast and slow transmitter, runs up to 4
        build(32'h2413_4214, bits, nb);
        packet(bits, nb, 19, 5, 1'b0, c0);
        verify(0, bits, nb, c0, 4, FS_P, 1'b0, "R5 fast filtered");
        verify(1, bits, nb, c0, 2, FS_P, 1'b0, "R5 fast direct");
        packet(bits, nb, 21, 5, 1'b0, c0);
        verify(0, bits, nb, c0, 4, FS_P, 1'b0, "R5 slow filtered");
        verify(1, bits, nb, c0, 2, FS_P, 1'b0, "R5 slow direct");

        // R9: 15 bits without change gives only 7 strobes
        build(32'h0000_000F, bits, nb);
        packet(bits, nb, FS_P, 1, 1'b0, c0);
        for (int i = 0; i < 2; i++) chk(rn[i] == 7, "R9 run limit count", rn[i], 7);

        // R10: one-sample pulse on idle line
        rn[0] = 0;
        rn[1] = 0;
        drive(1'b0, 1'b1, 1);
        drive(1'b1, 1'b0, 80);
        chk(rn[0] == 0, "R10 one-sample pulse filtered", rn[0], 0);
        chk(rn[1] == 7, "R10 one-sample pulse direct R8 lock", rn[1], 7);
        // R10: two-sample pulse passes the filter
        rn[0] = 0;
        rn[1] = 0;
        drive(1'b0, 1'b1, 2);
        drive(1'b1, 1'b0, 80);
        chk(rn[0] == 7, "R10 two-sample pulse filtered", rn[0], 7);
        // R7: single-ended hold after lock source removed gives nothing
        rn[0] = 0;
        rn[1] = 0;
        drive(1'b0, 1'b0, 40);
        drive(1'b1, 1'b0, 40);
        for (int i = 0; i < 2; i++) chk(rn[i] == 0, "R7 single-ended then idle", rn[i], 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule